// File: doc/BRIEF.md
# Combined Arithmetic, Logic and Shift Function Unit

This block is the combinational function unit of a register-to-register datapath. It receives two operand words, a 4-bit operation code and two serial fill bits. It returns one result word and four status flags: overflow, carry, negative and zero. The arithmetic part is a single adder. It adds operand A to one of four forms of operand B, plus a carry-in. The logic part provides four bitwise operations. A one-position shifter acts on operand B.

The surrounding datapath places the two bus values on the operand inputs and applies the operation code from its control word. It writes the result back in the same cycle. The block has no storage. Every output follows its inputs combinationally.

Top module: `func_unit`

## Requirements
- R1: For codes 0000 to 0111, the result is A + Y + k, modulo 2^WIDTH. Code bits [2:1] choose Y: 00 gives zero, 01 gives B, 10 gives the bitwise complement of B, and 11 gives all ones. Code bit 0 gives k. This yields A, A+1, A+B, A+B+1, A+~B, A+~B+1, A-1 and A.
- R2: For codes 0000 to 0111, flag_c is the bit that A + Y + k produces above bit WIDTH-1.
- R3: For codes 0000 to 0111, flag_v is 1 exactly when A and Y have the same sign bit and the result's sign bit differs from it.
- R4: Code 1000 gives A AND B, 1001 gives A OR B, 1010 gives A XOR B, and 1011 gives NOT A.
- R5: Code 1100 passes B to the result unchanged.
- R6: Code 1101 shifts B right by one position. fill_r enters the most significant bit.
- R7: Code 1110 shifts B left by one position. fill_l enters bit 0.
- R8: Code 1111 gives an all-zero result.
- R9: For every code with bit 3 set, flag_c and flag_v are 0.
- R10: For every code, flag_n equals the most significant bit of the result, and flag_z is 1 exactly when the result is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | WIDTH | Operand A |
| b | input | WIDTH | Operand B, also the shifter source |
| fs | input | 4 | Operation code |
| fill_r | input | 1 | Bit entering the MSB on a right shift |
| fill_l | input | 1 | Bit entering the LSB on a left shift |
| f | output | WIDTH | Result word |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Carry out |
| flag_n | output | 1 | Result sign |
| flag_z | output | 1 | Result is zero |

## Verification
The result and all four flags are due in the same cycle as the inputs, with zero register stages between them. The bench changes the operands, the code and the fill bits on the falling clock edge. On the following rising edge it compares every output with a behavioural model, so each comparison sees settled logic. Directed vectors cover the carry and overflow corners of each arithmetic code, subtracting one from zero, and both fill values on each shift. A deterministic pseudo-random sweep then covers all sixteen codes.

// File: rtl/fu_pkg.sv
package fu_pkg;
    typedef enum logic [1:0] {
        Y_ZERO = 2'b00,
        Y_PASS = 2'b01,
        Y_INV  = 2'b10,
        Y_ONES = 2'b11
    } ysel_e;

    typedef enum logic [1:0] {
        SH_PASS  = 2'b00,
        SH_RIGHT = 2'b01,
        SH_LEFT  = 2'b10,
        SH_NONE  = 2'b11
    } shmode_e;

    typedef enum logic [1:0] {
        LG_AND = 2'b00,
        LG_OR  = 2'b01,
        LG_XOR = 2'b10,
        LG_NOT = 2'b11
    } lgop_e;
endpackage

// File: rtl/fu_arith.sv
module fu_arith #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [2:0]       sel,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    import fu_pkg::*;
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] y_d;
    logic [WIDTH:0]   wide_d;
    ysel_e            ysel;

    always_comb begin
        ysel = ysel_e'(sel[2:1]);
        unique case (ysel)
            Y_ZERO:  y_d = '0;
            Y_PASS:  y_d = b;
            Y_INV:   y_d = ~b;
            default: y_d = '1;
        endcase
        wide_d = {1'b0, a} + {1'b0, y_d} + {{WIDTH{1'b0}}, sel[0]};
        sum    = wide_d[MSB:0];
        cout   = wide_d[WIDTH];
        ovf    = (a[MSB] == y_d[MSB]) && (wide_d[MSB] != a[MSB]);
    end
endmodule

// File: rtl/fu_logic.sv
module fu_logic #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] res
);
    import fu_pkg::*;
    lgop_e op;

    always_comb begin
        op = lgop_e'(sel);
        unique case (op)
            LG_AND:  res = a & b;
            LG_OR:   res = a | b;
            LG_XOR:  res = a ^ b;
            default: res = ~a;
        endcase
    end
endmodule

// File: rtl/fu_shift.sv
module fu_shift #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       sel,
    input  logic             fill_r,
    input  logic             fill_l,
    output logic [WIDTH-1:0] res
);
    import fu_pkg::*;
    localparam int MSB = WIDTH - 1;
    shmode_e mode;

    always_comb begin
        mode = shmode_e'(sel);
        unique case (mode)
            SH_PASS:  res = b;
            SH_RIGHT: res = {fill_r, b[MSB:1]};
            SH_LEFT:  res = {b[MSB-1:0], fill_l};
            default:  res = '0;
        endcase
    end
endmodule

// File: rtl/func_unit.sv
module func_unit #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [3:0]       fs,
    input  logic             fill_r,
    input  logic             fill_l,
    output logic [WIDTH-1:0] f,
    output logic             flag_v,
    output logic             flag_c,
    output logic             flag_n,
    output logic             flag_z
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] word;
        logic             v;
        logic             c;
    } out_t;

    logic [WIDTH-1:0] arith_sum;
    logic             arith_c;
    logic             arith_v;
    logic [WIDTH-1:0] logic_res;
    logic [WIDTH-1:0] shift_res;
    out_t             out_d;

    fu_arith #(.WIDTH(WIDTH)) u_arith (
        .a(a), .b(b), .sel(fs[2:0]),
        .sum(arith_sum), .cout(arith_c), .ovf(arith_v)
    );

    fu_logic #(.WIDTH(WIDTH)) u_logic (
        .a(a), .b(b), .sel(fs[1:0]), .res(logic_res)
    );

    fu_shift #(.WIDTH(WIDTH)) u_shift (
        .b(b), .sel(fs[1:0]), .fill_r(fill_r), .fill_l(fill_l),
        .res(shift_res)
    );

    always_comb begin
        if (fs[3] && fs[2]) begin
            out_d = '{word: shift_res, v: 1'b0, c: 1'b0};
        end else if (fs[3]) begin
            out_d = '{word: logic_res, v: 1'b0, c: 1'b0};
        end else begin
            out_d = '{word: arith_sum, v: arith_v, c: arith_c};
        end
    end

    assign f      = out_d.word;
    assign flag_v = out_d.v;
    assign flag_c = out_d.c;
    assign flag_n = out_d.word[MSB];
    assign flag_z = (out_d.word == '0);
endmodule

// File: rtl/func_unit_chk.sv
module func_unit_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [3:0]       fs,
    input logic             fill_r,
    input logic             fill_l,
    input logic [WIDTH-1:0] f,
    input logic             flag_v,
    input logic             flag_c,
    input logic             flag_n,
    input logic             flag_z
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        a_r1_identity_codes: assert (!(fs == 4'b0000 || fs == 4'b0111) || f == a);
        a_r1_add: assert (!(fs == 4'b0010) || f == a + b);
        a_r4_not_a: assert (!(fs == 4'b1011) || f == ~a);
        a_r5_pass_b: assert (!(fs == 4'b1100) || f == b);
        a_r6_fill_r: assert (!(fs == 4'b1101) || (f[MSB] == fill_r && f[MSB-1:0] == b[MSB:1]));
        a_r7_fill_l: assert (!(fs == 4'b1110) || (f[0] == fill_l && f[MSB:1] == b[MSB-1:0]));
        a_r8_unused_zero: assert (!(fs == 4'b1111) || (f == '0 && flag_z));
        a_r9_no_flags: assert (!fs[3] || (!flag_c && !flag_v));
        a_r10_zero_not_neg: assert (!flag_z || !flag_n);
    end
endmodule

bind func_unit func_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .a(a), .b(b), .fs(fs), .fill_r(fill_r), .fill_l(fill_l),
    .f(f), .flag_v(flag_v), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
);

// File: tb/sim_func_unit.sv
module sim_func_unit;
    localparam int W    = 8;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic [W-1:0] a = '0, b = '0;
    logic [3:0]   fs = '0;
    logic         fill_r = 1'b0, fill_l = 1'b0;
    logic [W-1:0] f;
    logic         flag_v, flag_c, flag_n, flag_z;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    func_unit #(.WIDTH(W)) u0 (
        .a(a), .b(b), .fs(fs), .fill_r(fill_r), .fill_l(fill_l),
        .f(f), .flag_v(flag_v), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s fs=%b a=%h b=%h actual=%h expected=%h", req, fs, a, b, act, exp);
        end
    endtask

    task automatic apply(input int ai, input int bi, input int code, input bit ir, input bit il);
        int ef, ec, ev, y, s, sa, sy;
        string rf;
        @(negedge clk);
        a = W'(ai); b = W'(bi); fs = 4'(code); fill_r = ir; fill_l = il;
        ec = 0; ev = 0;
        if (code < 8) begin
            case ((code >> 1) & 3)
                0: y = 0;
                1: y = bi;
                2: y = (~bi) & MASK;
                default: y = MASK;
            endcase
            s  = ai + y + (code & 1);
            ef = s & MASK;
            ec = (s >> W) & 1;
            sa = (ai >> (W-1)) & 1;
            sy = (y >> (W-1)) & 1;
            ev = (sa == sy && ((ef >> (W-1)) & 1) != sa) ? 1 : 0;
            rf = "R1";
        end else if (code < 12) begin
            case (code)
                8: ef = ai & bi;
                9: ef = ai | bi;
                10: ef = ai ^ bi;
                default: ef = (~ai) & MASK;
            endcase
            rf = "R4";
        end else if (code == 12) begin
            ef = bi; rf = "R5";
        end else if (code == 13) begin
            ef = (bi >> 1) | (int'(ir) << (W-1)); rf = "R6";
        end else if (code == 14) begin
            ef = ((bi << 1) & MASK) | int'(il); rf = "R7";
        end else begin
            ef = 0; rf = "R8";
        end
        @(posedge clk);
        #1;
        check(rf, int'(f), ef);
        check(code < 8 ? "R2" : "R9", int'(flag_c), ec);
        check(code < 8 ? "R3" : "R9", int'(flag_v), ev);
        check("R10", int'(flag_n), (ef >> (W-1)) & 1);
        check("R10", int'(flag_z), ef == 0 ? 1 : 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // reset-like idle state: all inputs zero, code 0000
        @(posedge clk); #1;
        check("R10", int'(flag_z), 1);
        check("R1", int'(f), 0);
        // R2/R3 corners
        apply(8'hFF, 8'h00, 1, 0, 0);   // wrap to zero with carry
        apply(8'h7F, 8'h00, 1, 0, 0);   // signed overflow on increment
        apply(8'h7F, 8'h01, 2, 0, 0);
        apply(8'h80, 8'h80, 2, 0, 0);   // negative overflow, carry
        apply(8'h00, 8'h00, 6, 0, 0);   // zero minus one
        apply(8'h80, 8'h00, 6, 0, 0);   // overflow on decrement
        apply(8'h05, 8'h05, 5, 0, 0);   // subtract equal
        apply(8'h80, 8'h01, 5, 0, 0);
        apply(8'h3C, 8'h11, 7, 0, 0);
        apply(8'h00, 8'h00, 7, 0, 0);
        apply(8'h12, 8'h34, 3, 0, 0);
        apply(8'h12, 8'h34, 4, 0, 0);
        apply(8'h00, 8'h55, 0, 0, 0);
        // logic R4
        apply(8'hF0, 8'h3C, 8, 0, 0);
        apply(8'hF0, 8'h3C, 9, 0, 0);
        apply(8'hF0, 8'hF0, 10, 0, 0);
        apply(8'hFF, 8'h00, 11, 0, 0);
        // shift R5..R8
        apply(8'h00, 8'hA5, 12, 1, 1);
        apply(8'h00, 8'h81, 13, 1, 0);
        apply(8'h00, 8'h81, 13, 0, 1);
        apply(8'h00, 8'h01, 13, 0, 0);
        apply(8'h00, 8'h81, 14, 0, 1);
        apply(8'h00, 8'h81, 14, 1, 0);
        apply(8'h00, 8'h80, 14, 0, 0);
        apply(8'hFF, 8'hFF, 15, 1, 1);
        // sweep
        for (int i = 0; i < 600; i++) begin
            apply(int'($urandom) & MASK, int'($urandom) & MASK, i % 16,
                  bit'($urandom & 1), bit'($urandom & 1));
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule